// File: doc/BRIEF.md
# Streaming Sample Mover with Split Request/Response Channels

This block is the data engine that sits between a filter core and the system memory. When a job starts, it reads a run of input samples from one memory area and hands them, in order, to the filter core through a read buffer. It collects the filtered results in a write buffer and stores them in a second memory area. The job settings (source start address, destination start address and number of words) are register outputs that the block captures when a job starts.

On the memory side, the block is a bus initiator. The request channel and the response channel each have their own valid/acknowledge pair, so a response can arrive any number of cycles after its request was accepted. Each response carries a tag that says whether it answers a read or a write. The block keeps counts of reads and writes that still owe a response. It issues a read only when the read buffer has room for that read and for every read still owed. This means it never has to refuse a response.

An `active` flag goes high when a job is accepted. It goes low once every read and write has been issued and answered and both buffers are empty. A power manager can use this flag to decide when to gate the block off.

Top module: `sample_mover`

## Requirements
- R1: After reset, `active`, `req_valid` and `smp_valid` are 0, and `res_ready` is 0.
- R2: A `start` pulse while `active` is 0 captures `src_base`, `dst_base` and `xfer_len`. `active` is 1 in the cycle after that edge.
- R3: Once `req_valid` is raised, it stays 1, and `req_addr`, `req_write` and (for a write) `req_wdata` stay unchanged, until a cycle in which `req_ack` is 1.
- R4: A job issues exactly `xfer_len` reads (`req_write`=0) at word addresses `src_base`, `src_base+1`, and so on, in that order.
- R5: The number of reads acknowledged but not yet answered, plus the words held in the read buffer, never exceeds the buffer depth (8). With a stalled filter core, this total reaches 8 and stops there.
- R6: Read-response data is delivered to the filter core on `smp_data` in request order. A word leaves the read buffer only in a cycle with `smp_valid` and `smp_ready` both 1.
- R7: A job issues exactly `xfer_len` writes (`req_write`=1) at `dst_base`, `dst_base+1`, and so on, in order. Each write carries the oldest result in the write buffer, and that entry is removed only when the write is acknowledged.
- R8: `rsp_ack` is always 1. A response with `rsp_write`=0 is a read answer and its `rsp_rdata` is stored. A response with `rsp_write`=1 only retires one pending write. The delay before a response has no bound.
- R9: When the write buffer holds 8 results, `res_ready` is 0 and no further result is taken.
- R10: `active` returns to 0 once all reads and writes of the job have been issued and answered and both buffers are empty. With `xfer_len`=0, `active` is 1 for exactly one cycle and no request is made.
- R11: A `start` pulse while `active` is 1 is ignored. The running job keeps its addresses and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a job when idle |
| src_base | input | AW | First source word address |
| dst_base | input | AW | First destination word address |
| xfer_len | input | LW | Words to move in each direction |
| req_valid | output | 1 | Request valid |
| req_ack | input | 1 | Request accepted by the bus side |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | AW | Request word address |
| req_wdata | output | DW | Write data (0 on reads) |
| rsp_valid | input | 1 | Response valid |
| rsp_write | input | 1 | Response tag: 1 answers a write |
| rsp_rdata | input | DW | Read response data |
| rsp_ack | output | 1 | Response taken (always 1) |
| smp_valid | output | 1 | Sample available to the filter core |
| smp_data | output | DW | Sample to the filter core |
| smp_ready | input | 1 | Filter core takes the sample |
| res_valid | input | 1 | Filter core offers a result |
| res_data | input | DW | Result from the filter core |
| res_ready | output | 1 | Result accepted into the write buffer |
| active | output | 1 | Job in progress |

## Verification
The bench varies acknowledge gaps, response delays and core stalls so that the credit check on reads is pushed to its limit. A design that counted only buffered words, and not owed responses, would let more than eight reads be in flight and overflow the read buffer. One test holds off write acknowledges until the write buffer fills. A design that popped the write buffer on issue, or ignored the full flag, would lose or duplicate results in the destination area. Separate tests cover a zero-length job, which must raise and drop `active` without any request, and a second `start` during a job, which must not redirect the addresses.

// File: rtl/sample_mover.sv
`timescale 1ns/1ps
module sample_mover #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int LW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [LW-1:0] xfer_len,
  output logic          req_valid,
  input  logic          req_ack,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic          rsp_write,
  input  logic [DW-1:0] rsp_rdata,
  output logic          rsp_ack,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  input  logic          smp_ready,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  output logic          active
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [1:0] {K_NONE, K_RD, K_WR} kind_t;
  kind_t cur;

  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] len_q, rd_iss, wr_iss;
  logic [CW-1:0] rd_out;
  logic [LW:0]   wr_out;

  logic [DW-1:0] rf_mem [DEPTH];
  logic [PW-1:0] rf_wp, rf_rp;
  logic [CW-1:0] rf_cnt;
  logic [DW-1:0] wf_mem [DEPTH];
  logic [PW-1:0] wf_wp, wf_rp;
  logic [CW-1:0] wf_cnt;

  logic acc, rd_acc, wr_acc, rd_rsp, wr_rsp;
  logic rf_push, rf_pop, wf_push, wf_pop;
  logic rd_ok, wr_ok, all_done, launch;

  assign launch    = start && !active;
  assign acc       = req_valid && req_ack;
  assign rd_acc    = acc && !req_write;
  assign wr_acc    = acc && req_write;
  assign rsp_ack   = 1'b1;
  assign rd_rsp    = rsp_valid && rsp_ack && !rsp_write;
  assign wr_rsp    = rsp_valid && rsp_ack && rsp_write;

  assign rf_push   = rd_rsp;
  assign rf_pop    = smp_valid && smp_ready;
  assign wf_push   = res_valid && res_ready;
  assign wf_pop    = wr_acc;

  assign smp_valid = rf_cnt != '0;
  assign smp_data  = rf_mem[rf_rp];
  assign res_ready = active && (wf_cnt != FULL);

  assign req_valid = cur != K_NONE;
  assign req_write = cur == K_WR;
  assign req_addr  = req_write ? dst_q + AW'(wr_iss) : src_q + AW'(rd_iss);
  assign req_wdata = req_write ? wf_mem[wf_rp] : '0;

  assign rd_ok = active && (rd_iss != len_q) &&
                 (({1'b0, rf_cnt} + {1'b0, rd_out}) < {1'b0, FULL});
  assign wr_ok = active && (wr_iss != len_q) && (wf_cnt != '0);

  assign all_done = (rd_iss == len_q) && (wr_iss == len_q) &&
                    (rd_out == '0) && (wr_out == '0) &&
                    (rf_cnt == '0) && (wf_cnt == '0) && (cur == K_NONE);

  // job control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
    end else if (launch) begin
      active <= 1'b1;
      src_q  <= src_base;
      dst_q  <= dst_base;
      len_q  <= xfer_len;
    end else if (active && all_done) begin
      active <= 1'b0;
    end
  end

  // request sequencing: reads first, one idle cycle after each acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= K_NONE;
    end else if (!active) begin
      cur <= K_NONE;
    end else if (cur == K_NONE) begin
      if (rd_ok)      cur <= K_RD;
      else if (wr_ok) cur <= K_WR;
    end else if (req_ack) begin
      cur <= K_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_iss <= '0;
      wr_iss <= '0;
      rd_out <= '0;
      wr_out <= '0;
    end else if (launch) begin
      rd_iss <= '0;
      wr_iss <= '0;
    end else begin
      if (rd_acc) rd_iss <= rd_iss + 1'b1;
      if (wr_acc) wr_iss <= wr_iss + 1'b1;
      case ({rd_acc, rd_rsp})
        2'b10:   rd_out <= rd_out + 1'b1;
        2'b01:   rd_out <= rd_out - 1'b1;
        default: rd_out <= rd_out;
      endcase
      case ({wr_acc, wr_rsp})
        2'b10:   wr_out <= wr_out + 1'b1;
        2'b01:   wr_out <= wr_out - 1'b1;
        default: wr_out <= wr_out;
      endcase
    end
  end

  // read buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_wp  <= '0;
      rf_rp  <= '0;
      rf_cnt <= '0;
    end else begin
      if (rf_push) rf_wp <= (rf_wp == LAST) ? '0 : rf_wp + 1'b1;
      if (rf_pop)  rf_rp <= (rf_rp == LAST) ? '0 : rf_rp + 1'b1;
      if (rf_push && !rf_pop)      rf_cnt <= rf_cnt + 1'b1;
      else if (rf_pop && !rf_push) rf_cnt <= rf_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_push) rf_mem[rf_wp] <= rsp_rdata;
  end

  // write buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wf_wp  <= '0;
      wf_rp  <= '0;
      wf_cnt <= '0;
    end else begin
      if (wf_push) wf_wp <= (wf_wp == LAST) ? '0 : wf_wp + 1'b1;
      if (wf_pop)  wf_rp <= (wf_rp == LAST) ? '0 : wf_rp + 1'b1;
      if (wf_push && !wf_pop)      wf_cnt <= wf_cnt + 1'b1;
      else if (wf_pop && !wf_push) wf_cnt <= wf_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wf_push) wf_mem[wf_wp] <= res_data;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_write)
                                 && (!req_write || $stable(req_wdata))));

  p_inflight_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rf_cnt} + {1'b0, rd_out}) <= {1'b0, FULL});

  p_rd_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (rd_iss != len_q));

  p_wr_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (wr_iss != len_q) && (wf_cnt != '0));

  p_rsp_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_write ? (wr_out != '0) : (rd_out != '0)));

  p_wf_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_cnt == FULL) |-> !res_ready);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !req_valid);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> $stable(src_q) && $stable(dst_q) && $stable(len_q));
endmodule

// File: tb/sample_mover_tb.sv
`timescale 1ns/1ps
module sample_mover_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] src_base = 0, dst_base = 0;
  logic [7:0]  xfer_len = 0;
  logic req_valid, req_write, req_ack = 0;
  logic [15:0] req_addr, req_wdata;
  logic rsp_valid = 0, rsp_write = 0, rsp_ack;
  logic [15:0] rsp_rdata = 0;
  logic smp_valid, smp_ready = 0;
  logic [15:0] smp_data;
  logic res_valid = 0, res_ready;
  logic [15:0] res_data = 0;
  logic active;

  sample_mover dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .xfer_len(xfer_len), .req_valid(req_valid), .req_ack(req_ack), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .active(active));

  always #2 clk = ~clk;

  // columns: src, dst, len, ack gap, response delay, core stall
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{0,  128, 5,  0, 1,  0},
    '{10, 140, 12, 2, 7,  1},
    '{30, 160, 20, 0, 3,  25},
    '{60, 190, 9,  3, 15, 0},
    '{80, 210, 1,  1, 30, 2}};

  int tests = 0, fails = 0, cyc = 0;
  int k_gap = 0, k_lat = 1, k_stall = 0;
  bit k_blkwr = 0;
  int src_k = 0, dst_k = 0, job = 0;
  int rd_tot = 0, wr_tot = 0, pop_tot = 0, res_tot = 0;
  int rd_base = 0, wr_base = 0, pop_base = 0, res_base = 0;
  int addr_err = 0, hold_err = 0;
  int peak_j [16];
  logic [15:0] mem [256];
  logic [15:0] qd [256];
  logic        qw [256];
  int          qdue [256];
  int qh = 0, qt = 0;
  logic [15:0] cq [256];
  int ch = 0, ct = 0;
  logic p_valid = 0, p_ack = 0, p_write = 0;
  logic [15:0] p_addr = 0, p_wdata = 0;

  function automatic logic [15:0] init_word(int a);
    return 16'(a * 311 + 43);
  endfunction

  task automatic chk(string req, bit ok, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory, bus side and filter core model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rsp_valid && rsp_ack) qh++;
      rsp_valid = 0;
      if (qh < qt && cyc >= qdue[qh % 256]) begin
        rsp_valid = 1;
        rsp_write = qw[qh % 256];
        rsp_rdata = qd[qh % 256];
      end
      if (req_valid && p_valid && !p_ack &&
          (req_addr != p_addr || req_write != p_write || (req_write && req_wdata != p_wdata)))
        hold_err++;
      req_ack = 0;
      if (req_valid && (cyc % (k_gap + 1)) == 0 && !(req_write && k_blkwr)) begin
        req_ack = 1;
        if (req_write) begin
          if (req_addr != 16'(dst_k + wr_tot - wr_base)) addr_err++;
          mem[req_addr[7:0]] = req_wdata;
          qw[qt % 256] = 1;
          qd[qt % 256] = 0;
          wr_tot++;
        end else begin
          if (req_addr != 16'(src_k + rd_tot - rd_base)) addr_err++;
          qw[qt % 256] = 0;
          qd[qt % 256] = mem[req_addr[7:0]];
          rd_tot++;
        end
        qdue[qt % 256] = cyc + k_lat;
        qt++;
      end
      p_valid = req_valid; p_ack = req_ack; p_write = req_write;
      p_addr = req_addr; p_wdata = req_wdata;
      if (res_valid) begin ch++; res_tot++; end
      res_valid = 0;
      if (ch < ct && res_ready) begin
        res_valid = 1;
        res_data = cq[ch % 256] ^ 16'h5A5A;
      end
      smp_ready = 0;
      if (smp_valid && (cyc % (k_stall + 1)) == 0) begin
        smp_ready = 1;
        cq[ct % 256] = smp_data;
        ct++;
        pop_tot++;
      end
      if (rd_tot - pop_tot > peak_j[job]) peak_j[job] = rd_tot - pop_tot;
    end
  end

  task automatic launch(int s, int d, int n);
    @(negedge clk);
    start = 1; src_base = 16'(s); dst_base = 16'(d); xfer_len = 8'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!active) begin ok = 1; break; end
    end
  endtask

  task automatic snap(int s, int d);
    job++;
    peak_j[job] = 0;
    src_k = s; dst_k = d;
    rd_base = rd_tot; wr_base = wr_tot; pop_base = pop_tot; res_base = res_tot;
  endtask

  task automatic check_dst(string req, int s, int d, int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[(d + i) % 256] != (init_word(s + i) ^ 16'h5A5A)) bad++;
    chk(req, bad == 0, bad, 0);
  endtask

  initial begin
    bit ok;
    int ae, he;
    for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    for (int i = 0; i < 16; i++) peak_j[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 active", active == 0, active, 0);
    chk("R1 req_valid", req_valid == 0, req_valid, 0);
    chk("R1 smp_valid/res_ready", !smp_valid && !res_ready, {smp_valid, res_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", !active && !req_valid, {active, req_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VEC[v][2]; i++) mem[VEC[v][1] + i] = 16'hDEAD;
      k_gap = VEC[v][3]; k_lat = VEC[v][4]; k_stall = VEC[v][5];
      snap(VEC[v][0], VEC[v][1]);
      ae = addr_err; he = hold_err;
      launch(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk("R2 active after start", active == 1, active, 1);
      wait_idle(ok);
      chk("R10 job finishes", ok, ok, 1);
      chk("R4 read count", rd_tot - rd_base == VEC[v][2], rd_tot - rd_base, VEC[v][2]);
      chk("R7 write count", wr_tot - wr_base == VEC[v][2], wr_tot - wr_base, VEC[v][2]);
      chk("R4/R7 address order", addr_err == ae, addr_err - ae, 0);
      chk("R3 request hold", hold_err == he, hold_err - he, 0);
      chk("R6 samples to core", pop_tot - pop_base == VEC[v][2], pop_tot - pop_base, VEC[v][2]);
      chk("R8 responses drained", qh == qt, qt - qh, 0);
      check_dst("R6/R7 data", VEC[v][0], VEC[v][1], VEC[v][2]);
      if (VEC[v][5] >= 10)
        chk("R5 peak in flight", peak_j[job] == 8, peak_j[job], 8);
      else
        chk("R5 in-flight cap", peak_j[job] <= 8, peak_j[job], 8);
    end

    // R9: write acks held off until the write buffer fills
    k_gap = 0; k_lat = 2; k_stall = 0; k_blkwr = 1;
    for (int i = 0; i < 16; i++) mem[240 + i] = 16'hDEAD;
    snap(40, 240);
    launch(40, 240, 16);
    repeat (300) @(negedge clk);
    chk("R9 results taken", res_tot - res_base == 8, res_tot - res_base, 8);
    chk("R9 res_ready low", res_ready == 0, res_ready, 0);
    chk("R7 no write before ack", mem[240] == 16'hDEAD, mem[240], 16'hDEAD);
    k_blkwr = 0;
    wait_idle(ok);
    chk("R10 finishes after release", ok, ok, 1);
    check_dst("R7 data after full", 40, 240, 16);

    // R11: second start during a job
    k_lat = 5;
    for (int i = 0; i < 6; i++) mem[230 + i] = 16'hDEAD;
    for (int i = 0; i < 3; i++) mem[128 + i] = 16'hDEAD;
    snap(100, 230);
    ae = addr_err;
    launch(100, 230, 6);
    repeat (3) @(negedge clk);
    launch(0, 128, 3);
    wait_idle(ok);
    chk("R11 counts unchanged", (rd_tot - rd_base == 6) && (wr_tot - wr_base == 6),
        wr_tot - wr_base, 6);
    chk("R11 addresses unchanged", addr_err == ae, addr_err - ae, 0);
    check_dst("R11 data", 100, 230, 6);
    chk("R11 other area untouched", mem[128] == 16'hDEAD, mem[128], 16'hDEAD);

    // R10: zero-length job
    snap(0, 0);
    launch(0, 0, 0);
    chk("R10 zero-length active one cycle", active == 1, active, 1);
    @(negedge clk);
    chk("R10 zero-length drops", active == 0, active, 0);
    repeat (5) @(negedge clk);
    chk("R10 zero-length no requests", (rd_tot == rd_base) && (wr_tot == wr_base),
        rd_tot - rd_base + wr_tot - wr_base, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule